// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block collects level-sensitive interrupt requests from up to 63 peripheral sources and presents one external-interrupt request to a single hart. Each source passes through a small gateway that latches a pending flag and then holds the source off while software services it. An arbiter picks the best candidate among sources that are enabled, pending and above a programmable threshold. It compares the 3-bit priorities, and on equal priority the lower source number wins.

Software reaches the block through a one-cycle register port: a valid strobe, a write flag, a byte address and 32-bit write data. Read data comes back registered on the following cycle. Software reads the claim/complete register to take ownership of the winning source, which clears that source's pending flag on the same edge. After servicing, software writes the source number back to the same address to let the source request again. The completion is not compared with the most recent claim, but it only counts when the named source is enabled at that moment.

Source 0 is reserved and never requests. The layout is: priorities at byte 0x000 + 4·n, pending words at 0x100 + 4·w, enable words at 0x180 + 4·w, threshold at 0x200, claim/complete at 0x204. `NUM_SRC` is a multiple of 32 and at most 64.

Top module: `pic_core`

## Requirements
- R1: After reset every priority, every enable bit, every pending bit and the threshold are 0, no source is claimed, `irq_o` is low, and a claim read returns 0.
- R2: The priority of source n (1..NUM_SRC-1) is a 3-bit register at byte 0x000 + 4·n, written from wdata[2:0] and read back zero-extended. Source 0's priority reads 0 and ignores writes.
- R3: Enable word w sits at byte 0x180 + 4·w and holds source n at word n/32, bit n%32. Bit 0 of word 0 always reads 0.
- R4: Pending word w is read-only at byte 0x100 + 4·w with the enable packing. A pending bit sets on the edge after the source input is sampled high while the source is neither pending nor claimed. It stays set when the input falls. Source 0 never becomes pending.
- R5: The threshold is a 3-bit register at byte 0x200. A source is eligible only when it is enabled, pending and its priority is strictly above the threshold. Threshold 0 admits every nonzero priority, threshold 7 admits none, and priority 0 is never eligible.
- R6: `irq_o` is high exactly when at least one source is eligible. It reflects the register state after each clock edge.
- R7: A read of byte 0x204 returns the eligible source with the highest priority. Among equal priorities it returns the lowest source number. It returns 0 when no source is eligible.
- R8: Read data appears on `rsp_rdata_o` in the cycle after the read request and is held until the next read. Unmapped or misaligned addresses read 0, and writes to them or to pending words change nothing.
- R9: A claim read that returns source n clears n's pending bit on that edge and marks n claimed. A claimed source does not become pending again while its input stays high.
- R10: A write of value n to byte 0x204 releases claimed source n when n is enabled, whatever was last claimed. It is ignored when n is disabled, 0 or not below NUM_SRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC (64) | Level interrupt inputs, bit n for source n; bit 0 unused |
| req_valid_i | input | 1 | Register access strobe, one access per cycle |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 10 | Byte address of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Registered read data, valid the cycle after a read |
| irq_o | output | 1 | External interrupt request to the hart |

## Verification
The bench targets priority ties, a higher priority at a higher source number, and thresholds equal to a source's priority. An arbiter with the tie order reversed, or one that compares with greater-or-equal, returns the wrong number or raises `irq_o` when it should not. It holds inputs high across a claim, which exposes a gateway that lets a claimed source go pending again. It completes a source while that source is disabled, which exposes a design that releases the claim anyway. Random traffic then mixes these with completions of numbers never claimed or out of range, and compares every read and every `irq_o` sample with a bench model.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned PRIO_W   = 3;
  localparam int unsigned ADDR_W   = 10;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned PRIO_BASE  = 'h000;
  localparam int unsigned PEND_BASE  = 'h100;
  localparam int unsigned EN_BASE    = 'h180;
  localparam int unsigned THR_ADDR   = 'h200;
  localparam int unsigned CLAIM_ADDR = 'h204;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [ADDR_W-1:0] addr_t;

  function automatic addr_t prio_addr(input int unsigned n);
    return addr_t'(PRIO_BASE + 4 * n);
  endfunction

  function automatic addr_t pend_addr(input int unsigned w);
    return addr_t'(PEND_BASE + 4 * w);
  endfunction

  function automatic addr_t en_addr(input int unsigned w);
    return addr_t'(EN_BASE + 4 * w);
  endfunction

  // strict comparison: an equal priority never displaces the earlier candidate
  function automatic logic outranks(input prio_t cand, input prio_t best);
    return cand > best;
  endfunction
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  addr_t                addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output prio_t                prio_o [NUM_SRC],
  output logic [NUM_SRC-1:0]   en_o,
  output prio_t                thr_o
);
  localparam int unsigned NWORDS = NUM_SRC / WORD_W;

  prio_t              prio_q [NUM_SRC];
  logic [NUM_SRC-1:0] en_q;
  prio_t              thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NUM_SRC; n++) prio_q[n] <= '0;
      en_q  <= '0;
      thr_q <= '0;
    end else if (wr_i) begin
      for (int n = 1; n < NUM_SRC; n++)
        if (addr_i == prio_addr(n)) prio_q[n] <= wdata_i[PRIO_W-1:0];
      for (int w = 0; w < NWORDS; w++)
        if (addr_i == en_addr(w))
          en_q[w*WORD_W +: WORD_W] <= wdata_i & ((w == 0) ? 32'hFFFF_FFFE : 32'hFFFF_FFFF);
      if (addr_i == addr_t'(THR_ADDR)) thr_q <= wdata_i[PRIO_W-1:0];
    end
  end

  assign prio_o = prio_q;
  assign en_o   = en_q;
  assign thr_o  = thr_q;

  assert_prio_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == prio_addr(1)) |=> (prio_q[1] == $past(wdata_i[PRIO_W-1:0])));

  assert_src0_enable_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == en_addr(0)) |=> !en_q[0]);
endmodule

// File: rtl/pic_gateway.sv
module pic_gateway (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic claim_i,
  input  logic complete_i,
  input  logic en_i,
  output logic pend_o,
  output logic claimed_o
);
  logic pend_q, claimed_q;
  logic release_ok;

  assign release_ok = complete_i && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      claimed_q <= 1'b0;
    end else if (claim_i) begin
      pend_q    <= 1'b0;
      claimed_q <= 1'b1;
    end else begin
      if (src_i && !pend_q && !claimed_q) pend_q <= 1'b1;
      if (release_ok) claimed_q <= 1'b0;
    end
  end

  assign pend_o    = pend_q;
  assign claimed_o = claimed_q;

  assert_no_repend_while_claimed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claimed_q |=> !pend_q);

  assert_ignored_completion_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete_i && !en_i && !claim_i) |=> (claimed_q == $past(claimed_q)));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ID_W    = $clog2(NUM_SRC)
) (
  input  prio_t              prio_i [NUM_SRC],
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  prio_t              thr_i,
  output logic [ID_W-1:0]    id_o,
  output prio_t              prio_o,
  output logic               any_o
);
  // scanning upward from the threshold keeps the lowest number on equal priority
  always_comb begin
    id_o   = '0;
    prio_o = thr_i;
    any_o  = 1'b0;
    for (int n = 1; n < NUM_SRC; n++) begin
      if (en_i[n] && pend_i[n] && outranks(prio_i[n], prio_o)) begin
        id_o   = ID_W'(n);
        prio_o = prio_i[n];
        any_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [WORD_W-1:0]  req_wdata_i,
  output logic [WORD_W-1:0]  rsp_rdata_o,
  output logic               irq_o
);
  localparam int unsigned ID_W   = $clog2(NUM_SRC);
  localparam int unsigned NWORDS = NUM_SRC / WORD_W;

  prio_t              prio [NUM_SRC];
  logic [NUM_SRC-1:0] en, pend, claimed;
  prio_t              thr;
  logic [ID_W-1:0]    best_id;
  prio_t              best_prio;
  logic               best_any;

  // named events for the assertions
  logic cfg_write, claim_fire, complete_fire;
  logic [WORD_W-1:0] rd_value;
  logic [WORD_W-1:0] rdata_q;

  assign cfg_write     = req_valid_i && req_write_i;
  assign claim_fire    = req_valid_i && !req_write_i && (req_addr_i == addr_t'(CLAIM_ADDR));
  assign complete_fire = cfg_write && (req_addr_i == addr_t'(CLAIM_ADDR));

  pic_cfg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cfg_write),
    .addr_i (req_addr_i),
    .wdata_i(req_wdata_i),
    .prio_o (prio),
    .en_o   (en),
    .thr_o  (thr)
  );

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_gw
    pic_gateway u_gw (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_i[n] && (n != 0)),
      .claim_i   (claim_fire && best_any && (best_id == ID_W'(n))),
      .complete_i(complete_fire && (req_wdata_i == WORD_W'(n))),
      .en_i      (en[n]),
      .pend_o    (pend[n]),
      .claimed_o (claimed[n])
    );
  end

  pic_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
    .prio_i(prio),
    .en_i  (en),
    .pend_i(pend),
    .thr_i (thr),
    .id_o  (best_id),
    .prio_o(best_prio),
    .any_o (best_any)
  );

  assign irq_o = best_any;

  always_comb begin
    rd_value = '0;
    for (int n = 0; n < NUM_SRC; n++)
      if (req_addr_i == prio_addr(n)) rd_value = WORD_W'(prio[n]);
    for (int w = 0; w < NWORDS; w++) begin
      if (req_addr_i == pend_addr(w)) rd_value = pend[w*WORD_W +: WORD_W];
      if (req_addr_i == en_addr(w))   rd_value = en[w*WORD_W +: WORD_W];
    end
    if (req_addr_i == addr_t'(THR_ADDR))   rd_value = WORD_W'(thr);
    if (req_addr_i == addr_t'(CLAIM_ADDR)) rd_value = best_any ? WORD_W'(best_id) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rdata_q <= '0;
    else if (req_valid_i && !req_write_i) rdata_q <= rd_value;
  end

  assign rsp_rdata_o = rdata_q;

  assert_irq_above_threshold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (best_prio > thr));

  assert_winner_eligible_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en[best_id] && pend[best_id] && !claimed[best_id] && best_id != '0));

  assert_claim_clears_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_fire && best_any) |=> (!pend[$past(best_id)] && claimed[$past(best_id)]));

  assert_rdata_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> $stable(rsp_rdata_o));
endmodule

// File: tb/pic_core_bench.sv
module pic_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 64;
  localparam logic [9:0] A_PEND  = 10'h100;
  localparam logic [9:0] A_EN    = 10'h180;
  localparam logic [9:0] A_THR   = 10'h200;
  localparam logic [9:0] A_CLAIM = 10'h204;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_tests = 0, n_fail = 0;

  int m_prio [NS];
  bit m_en   [NS];
  bit m_pend [NS];
  bit m_clm  [NS];
  int m_thr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_core #(.NUM_SRC(NS)) u_pic_core (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_rdata_o(rdata), .irq_o(irq)
  );

  function automatic int f_best();
    int top = 0;
    for (int n = 1; n < NS; n++)
      if (m_en[n] && m_pend[n] && m_prio[n] > m_thr && m_prio[n] > top) top = m_prio[n];
    if (top == 0) return 0;
    for (int n = 1; n < NS; n++)
      if (m_en[n] && m_pend[n] && m_prio[n] == top) return n;
    return 0;
  endfunction

  function automatic logic [31:0] f_read(input logic [9:0] a);
    logic [31:0] r;
    r = '0;
    for (int n = 0; n < NS; n++) if (a == 10'(4*n)) r = 32'(m_prio[n]);
    for (int w = 0; w < NS/32; w++) begin
      if (a == A_PEND + 10'(4*w)) for (int b = 0; b < 32; b++) r[b] = m_pend[32*w+b];
      if (a == A_EN   + 10'(4*w)) for (int b = 0; b < 32; b++) r[b] = m_en[32*w+b];
    end
    if (a == A_THR)   r = 32'(m_thr);
    if (a == A_CLAIM) r = 32'(f_best());
    return r;
  endfunction

  function automatic string tag_of(input logic [9:0] a);
    if (a < 10'h100) return "R2 priority read";
    if (a == A_PEND || a == A_PEND + 10'd4) return "R4 pending read";
    if (a == A_EN || a == A_EN + 10'd4) return "R3 enable read";
    if (a == A_THR) return "R5 threshold read";
    if (a == A_CLAIM) return "R7 claim read";
    return "R8 unmapped read";
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one register access; called at a falling edge, returns at the next falling edge
  task automatic step(input bit v, input bit w, input logic [9:0] a,
                      input logic [31:0] d, input string tag);
    logic [31:0] exp_rd;
    int cid;
    bit do_rd;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    do_rd  = v && !w;
    exp_rd = f_read(a);
    cid    = f_best();
    @(posedge clk);
    for (int n = 1; n < NS; n++) begin
      if (do_rd && a == A_CLAIM && cid == n) begin
        m_pend[n] = 1'b0;
        m_clm[n]  = 1'b1;
      end else begin
        if (src[n] && !m_pend[n] && !m_clm[n]) m_pend[n] = 1'b1;
        if (v && w && a == A_CLAIM && d == 32'(n) && m_en[n]) m_clm[n] = 1'b0;
      end
    end
    if (v && w) begin
      for (int n = 1; n < NS; n++) if (a == 10'(4*n)) m_prio[n] = int'(d[2:0]);
      for (int k = 0; k < NS/32; k++)
        if (a == A_EN + 10'(4*k)) for (int b = 0; b < 32; b++) m_en[32*k+b] = d[b];
      m_en[0] = 1'b0;
      if (a == A_THR) m_thr = int'(d[2:0]);
    end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (do_rd) check(rdata, exp_rd, tag);
    check(32'(irq), 32'(f_best() != 0), "R6 irq level");
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, "write");
  endtask
  task automatic rd(input logic [9:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'd0, tag);
  endtask
  task automatic idle();
    step(1'b0, 1'b0, 10'd0, 32'd0, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    for (int n = 0; n < NS; n++) begin
      m_prio[n] = 0; m_en[n] = 0; m_pend[n] = 0; m_clm[n] = 0;
    end
    m_thr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(32'(irq), 32'd0, "R1 irq after reset");
    rd(10'd20, "R1 priority after reset");
    rd(A_EN, "R1 enable after reset");
    rd(A_PEND, "R1 pending after reset");
    rd(A_THR, "R1 threshold after reset");
    rd(A_CLAIM, "R1 claim after reset");
    check(rdata, 32'd0, "R1 claim returns zero");

    // R2 priority width and source 0
    wr(10'd0, 32'd5);
    rd(10'd0, "R2 source 0 priority");
    check(rdata, 32'd0, "R2 source 0 priority stays zero");
    wr(10'd12, 32'hFFFF_FFFA);
    rd(10'd12, "R2 priority masking");
    check(rdata, 32'd2, "R2 only three bits kept");
    wr(10'd20, 32'd2);
    wr(10'd36, 32'd0);

    // R3 enable packing, bit 0 forced low
    wr(A_EN, 32'h0000_022B);
    rd(A_EN, "R3 enable word 0");
    check(rdata, 32'h0000_022A, "R3 bit 0 reads zero");

    // R4 pending latch
    src[3] = 1'b1; src[5] = 1'b1; src[9] = 1'b1; src[0] = 1'b1;
    idle();
    src[5] = 1'b0;
    rd(A_PEND, "R4 pending word 0");
    check(rdata, 32'h0000_0228, "R4 pending bits latched, source 0 never");
    wr(A_PEND, 32'h0);
    rd(A_PEND, "R8 pending write ignored");
    check(rdata, 32'h0000_0228, "R8 pending not writable");

    // R7 tie toward lowest id, R9 claim clears pending
    rd(A_CLAIM, "R7 first claim");
    check(rdata, 32'd3, "R7 tie goes to source 3");
    rd(A_CLAIM, "R7 second claim");
    check(rdata, 32'd5, "R7 then source 5");
    rd(A_CLAIM, "R7 nothing eligible");
    check(rdata, 32'd0, "R7 priority 0 source never wins");
    check(32'(irq), 32'd0, "R5 priority 0 gives no irq");
    idle(); idle();
    rd(A_PEND, "R9 claimed sources stay clear");
    check(rdata, 32'h0000_0200, "R9 no re-pend with input high");

    // R10 completion releases, pending returns
    wr(A_CLAIM, 32'd3);
    idle();
    check(32'(irq), 32'd1, "R10 released source requests again");
    rd(A_PEND, "R10 pending back");
    check(rdata, 32'h0000_0208, "R10 source 3 pending again");

    // R8 hold between reads, unmapped address
    held = rdata;
    wr(A_THR, 32'd0);
    check(rdata, held, "R8 read data held across writes");
    rd(10'h3F0, "R8 unmapped read");
    rd(10'h102, "R8 misaligned read");

    // R5 threshold
    wr(A_THR, 32'd2);
    check(32'(irq), 32'd0, "R5 threshold equal to priority masks");
    wr(A_THR, 32'd1);
    check(32'(irq), 32'd1, "R5 threshold below priority admits");
    wr(10'd12, 32'd7);
    wr(A_THR, 32'd7);
    check(32'(irq), 32'd0, "R5 threshold 7 masks all");
    wr(A_THR, 32'd0);

    // R7 higher priority beats lower id
    wr(10'd160, 32'd6);
    wr(A_EN + 10'd4, 32'h0000_0100);
    src[40] = 1'b1;
    wr(10'd12, 32'd2);
    rd(A_CLAIM, "R7 priority over id");
    check(rdata, 32'd40, "R7 source 40 at priority 6 wins");

    // R10 completion of a disabled source is ignored
    wr(A_EN + 10'd4, 32'h0);
    wr(A_CLAIM, 32'd40);
    wr(A_EN + 10'd4, 32'h0000_0100);
    idle();
    rd(A_PEND + 10'd4, "R10 disabled completion ignored");
    check(rdata, 32'h0, "R10 source 40 still claimed");
    wr(A_CLAIM, 32'd0);
    wr(A_CLAIM, 32'd100);
    wr(A_CLAIM, 32'd40);
    idle();
    rd(A_PEND + 10'd4, "R10 enabled completion accepted");
    check(rdata, 32'h0000_0100, "R10 source 40 pending again");

    // constrained random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [9:0] a;
      op = $urandom_range(0, 9);
      case (op)
        0: wr(10'(4 * $urandom_range(0, 63)), $urandom);
        1: wr(A_EN + 10'(4 * $urandom_range(0, 1)), $urandom);
        2: wr(A_THR, 32'($urandom_range(0, 3)));
        3, 4: rd(A_CLAIM, "R7 random claim");
        5, 6: wr(A_CLAIM, 32'($urandom_range(0, 70)));
        7: begin
          a = 10'($urandom_range(0, 'h20C)) & 10'h3FC;
          rd(a, tag_of(a));
        end
        8: begin
          src[$urandom_range(0, 63)] ^= 1'b1;
          idle();
        end
        default: idle();
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule